// File: doc/BRIEF.md
# Dual-Period Watchdog Timer

This block watches a supervised system for signs of life and raises a fault flag when none arrive in time. It counts ticks of a slow timebase, where each tick stands for one 6.25 ms unit. The count restarts whenever a chosen activity signal changes level. That signal can be one general-purpose input, one supervisor output, or both together. The fault flag goes to the output controllers of the supervisor, which decide how to act on it.

Two timeout lengths are kept apart. A startup length applies from the moment the watchdog is armed until the first restart. It gives a slow boot extra time and can be switched off. A running length applies after that. Each length is picked by a 3-bit code from eight values. Each value is four times the one before, from 1 tick to 16384 ticks (6.25 ms to 102.4 s). A master enable holds the whole watchdog idle and keeps the flag low.

Top module: `wdt_dual_period`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the next value of `wd_fault` is 0 and the watchdog is left unarmed.
- R2: While `cfg_enable` is 0, `wd_fault` is 0 from the next clock on, and ticks and source changes have no effect. After `cfg_enable` returns to 1, a fresh period starts as in R3 or R4.
- R3: The first enabled clock after reset or after a disable is an arming cycle, and a tick in that cycle is ignored. In that cycle, with `cfg_init_en`=1, the counter loads 4^`cfg_init_code` ticks. `wd_fault` rises after the clock that samples the last of those ticks.
- R4: With `cfg_init_en`=0, the arming cycle loads the running length 4^`cfg_norm_code`, and `cfg_init_code` has no effect.
- R5: After a restart or an expiry, each period lasts 4^`cfg_norm_code` ticks, counting the first tick sampled after the reload.
- R6: When `cfg_clr_mode` bit 0 is set, any change of `gpi[cfg_gpi_sel]` between two consecutive clocks, rising or falling, restarts the count with the running length.
- R7: When `cfg_clr_mode` bit 1 is set, any change of `po[cfg_po_sel]` between two consecutive clocks restarts the count in the same way.
- R8: With both mode bits set, a change on either selected signal restarts the count. Changes on bits that are not selected, or on a source whose mode bit is 0, have no effect.
- R9: On expiry, `wd_fault` goes to 1 and the counter reloads the running length. The flag then stays high until the next sampled tick, a restart, or a disable, whichever comes first.
- R10: When a restart and a tick land in the same clock, the restart wins: no count is taken and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase enable, one clock high per 6.25 ms unit |
| gpi | input | NUM_GPI | General-purpose inputs, candidate restart sources |
| po | input | NUM_PO | Supervisor outputs, candidate restart sources |
| cfg_enable | input | 1 | Master enable of the watchdog |
| cfg_init_en | input | 1 | Use the startup length for the first period |
| cfg_init_code | input | 3 | Startup length code, length 4^code ticks |
| cfg_norm_code | input | 3 | Running length code, length 4^code ticks |
| cfg_clr_mode | input | 2 | Bit 0 uses the chosen input, bit 1 uses the chosen output |
| cfg_gpi_sel | input | clog2(NUM_GPI) | Index of the chosen general-purpose input |
| cfg_po_sel | input | clog2(NUM_PO) | Index of the chosen supervisor output |
| wd_fault | output | 1 | Watchdog expiry flag |

## Verification
The count is internal and is seen only through the time at which `wd_fault` rises. A wrong count or a wrong reload length therefore shows up as a fault one or more ticks early or late. That error appears within one period of the fault. With short period codes the bench sees it within a few ticks. A bad edge detector or a bad choice of source shows up in the opposite way: a fault where activity was present, or no fault where activity was absent, within one period. A bench model steps in lockstep with the design and compares the flag on every clock. It also counts ticks to each fault, so a single-cycle slip in fault timing or fault clearing is seen at once.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CODE_W   = 3;
    localparam int LOG_STEP = 2;
    localparam int CNT_W    = LOG_STEP * ((1 << CODE_W) - 1) + 1;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic armed;
        logic fault;
        cnt_t cnt;
    } core_st_t;

    function automatic cnt_t len_of(input code_t code);
        return cnt_t'(1) << (LOG_STEP * int'(code));
    endfunction
endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
    import wdt_pkg::*;
(
    input  logic  init_en,
    input  code_t init_code,
    input  code_t norm_code,
    output cnt_t  start_len,
    output cnt_t  norm_len
);
    cnt_t init_len;

    always_comb begin
        init_len  = len_of(init_code);
        norm_len  = len_of(norm_code);
        start_len = init_en ? init_len : norm_len;
    end
endmodule

// File: rtl/wdt_clear_detect.sv
module wdt_clear_detect #(
    parameter int NUM_GPI = 4,
    parameter int NUM_PO  = 8,
    localparam int GSEL_W = $clog2(NUM_GPI),
    localparam int PSEL_W = $clog2(NUM_PO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_GPI-1:0] gpi,
    input  logic [NUM_PO-1:0]  po,
    input  logic [1:0]         mode,
    input  logic [GSEL_W-1:0]  gsel,
    input  logic [PSEL_W-1:0]  psel,
    output logic               clr
);
    typedef struct packed {
        logic [NUM_GPI-1:0] gpi_prev;
        logic [NUM_PO-1:0]  po_prev;
    } hist_t;

    hist_t h_d, h_q;
    logic  gpi_chg, po_chg;

    always_comb begin
        h_d.gpi_prev = gpi;
        h_d.po_prev  = po;
        gpi_chg      = gpi[gsel] ^ h_q.gpi_prev[gsel];
        po_chg       = po[psel]  ^ h_q.po_prev[psel];
        clr          = (mode[0] & gpi_chg) | (mode[1] & po_chg);
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    p_still_inputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(gpi) && $stable(po)) |-> !clr);
endmodule

// File: rtl/wdt_dual_period.sv
module wdt_dual_period
    import wdt_pkg::*;
#(
    parameter int NUM_GPI = 4,
    parameter int NUM_PO  = 8,
    localparam int GSEL_W = $clog2(NUM_GPI),
    localparam int PSEL_W = $clog2(NUM_PO)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NUM_GPI-1:0] gpi,
    input  logic [NUM_PO-1:0]  po,
    input  logic               cfg_enable,
    input  logic               cfg_init_en,
    input  logic [2:0]         cfg_init_code,
    input  logic [2:0]         cfg_norm_code,
    input  logic [1:0]         cfg_clr_mode,
    input  logic [GSEL_W-1:0]  cfg_gpi_sel,
    input  logic [PSEL_W-1:0]  cfg_po_sel,
    output logic               wd_fault
);
    core_st_t st_d, st_q;
    cnt_t     start_len, norm_len;
    logic     clr;

    wdt_period_sel u_len (
        .init_en   (cfg_init_en),
        .init_code (cfg_init_code),
        .norm_code (cfg_norm_code),
        .start_len (start_len),
        .norm_len  (norm_len)
    );

    wdt_clear_detect #(.NUM_GPI(NUM_GPI), .NUM_PO(NUM_PO)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .gpi   (gpi),
        .po    (po),
        .mode  (cfg_clr_mode),
        .gsel  (cfg_gpi_sel),
        .psel  (cfg_po_sel),
        .clr   (clr)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.armed = 1'b0;
            st_d.fault = 1'b0;
            st_d.cnt   = cnt_t'(1);
        end else if (!cfg_enable) begin
            st_d.armed = 1'b0;
            st_d.fault = 1'b0;
        end else if (clr) begin
            st_d.armed = 1'b1;
            st_d.fault = 1'b0;
            st_d.cnt   = norm_len;
        end else if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.cnt   = start_len;
        end else if (tick) begin
            if (st_q.cnt == cnt_t'(1)) begin
                st_d.fault = 1'b1;
                st_d.cnt   = norm_len;
            end else begin
                st_d.fault = 1'b0;
                st_d.cnt   = st_q.cnt - cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wd_fault = st_q.fault;

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !wd_fault);

    p_fault_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_fault) |-> $past(tick));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && clr) |=> (!wd_fault && st_q.cnt == $past(norm_len)));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && st_q.armed && !clr && !tick) |=> ($stable(st_q.cnt) && $stable(wd_fault)));

    p_cnt_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0);

    p_len_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(start_len) == 1 && $countones(norm_len) == 1);
endmodule

// File: tb/wdt_dual_period_tb_top.sv
`timescale 1ns/1ps
module wdt_dual_period_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, tick, cfg_enable, cfg_init_en;
    logic [3:0] gpi;
    logic [7:0] po;
    logic [2:0] cfg_init_code, cfg_norm_code;
    logic [1:0] cfg_clr_mode, cfg_gpi_sel;
    logic [2:0] cfg_po_sel;
    logic       wd_fault;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    int         m_cnt = 1;
    bit         m_armed = 0, m_fault = 0;
    logic [3:0] m_pg = '0;
    logic [7:0] m_pp = '0;

    always #2.5 clk = ~clk;

    wdt_dual_period dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gpi(gpi), .po(po),
        .cfg_enable(cfg_enable), .cfg_init_en(cfg_init_en),
        .cfg_init_code(cfg_init_code), .cfg_norm_code(cfg_norm_code),
        .cfg_clr_mode(cfg_clr_mode), .cfg_gpi_sel(cfg_gpi_sel),
        .cfg_po_sel(cfg_po_sel), .wd_fault(wd_fault)
    );

    function automatic int plen(input int c);
        return 1 << (2 * c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit hit;
        if (!rst_n) begin
            m_armed = 0; m_fault = 0; m_cnt = 1;
        end else begin
            hit = (cfg_clr_mode[0] && gpi[cfg_gpi_sel] != m_pg[cfg_gpi_sel]) ||
                  (cfg_clr_mode[1] && po[cfg_po_sel] != m_pp[cfg_po_sel]);
            if (!cfg_enable) begin
                m_armed = 0; m_fault = 0;
            end else if (hit) begin
                m_cnt = plen(cfg_norm_code); m_armed = 1; m_fault = 0;
            end else if (!m_armed) begin
                m_cnt = cfg_init_en ? plen(cfg_init_code) : plen(cfg_norm_code);
                m_armed = 1;
            end else if (tick) begin
                if (m_cnt == 1) begin
                    m_fault = 1; m_cnt = plen(cfg_norm_code);
                end else begin
                    m_cnt--; m_fault = 0;
                end
            end
        end
        m_pg = gpi;
        m_pp = po;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(wd_fault === m_fault, cur_req, int'(wd_fault), int'(m_fault));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(); tick = 1'b0; cyc();
        end
    endtask

    task automatic ticks_to_fault(input int maxn, output int n);
        n = -1;
        for (int i = 0; i < maxn; i++) begin
            tick = 1'b1; cyc(); tick = 1'b0;
            if (wd_fault === 1'b1) begin
                n = i + 1;
                break;
            end
            cyc();
        end
    endtask

    task automatic restart_off();
        cfg_enable = 1'b0; cyc();
    endtask

    int  n;
    bit  any_fault;

    initial begin
        rst_n = 1'b0; tick = 1'b0; gpi = '0; po = '0;
        cfg_enable = 1'b0; cfg_init_en = 1'b1; cfg_init_code = 3'd0;
        cfg_norm_code = 3'd0; cfg_clr_mode = 2'b00; cfg_gpi_sel = 2'd0; cfg_po_sel = 3'd0;
        @(negedge clk);
        cur_req = "R1";
        cyc(); cyc(); cyc();
        check(wd_fault === 1'b0, "R1", int'(wd_fault), 0);
        rst_n = 1'b1;

        // R2: disabled, ticks do nothing
        cur_req = "R2";
        cfg_enable = 1'b0;
        ticks(10);
        check(wd_fault === 1'b0, "R2", int'(wd_fault), 0);

        // R3: startup length 4 ticks, then running 16
        cur_req = "R3";
        cfg_init_code = 3'd1; cfg_norm_code = 3'd2; cfg_enable = 1'b1;
        tick = 1'b1; cyc(); tick = 1'b0; cyc();
        ticks_to_fault(100, n);
        check(n == 4, "R3", n, 4);

        // R9: fault held until next tick, then drops
        cur_req = "R9";
        for (int i = 0; i < 5; i++) cyc();
        check(wd_fault === 1'b1, "R9", int'(wd_fault), 1);
        tick = 1'b1; cyc(); tick = 1'b0;
        check(wd_fault === 1'b0, "R9", int'(wd_fault), 0);
        cyc();

        // R5: remaining ticks of running period
        cur_req = "R5";
        ticks_to_fault(100, n);
        check(n == 15, "R5", n, 15);

        // R2: disable while fault high drops it next clock
        cur_req = "R2";
        restart_off();
        check(wd_fault === 1'b0, "R2", int'(wd_fault), 0);
        cfg_init_en = 1'b1; cfg_init_code = 3'd0; cfg_enable = 1'b1;
        cyc();
        ticks_to_fault(10, n);
        check(n == 1, "R2", n, 1);

        // R4: startup length skipped
        cur_req = "R4";
        restart_off();
        cfg_init_en = 1'b0; cfg_init_code = 3'd3; cfg_norm_code = 3'd1; cfg_enable = 1'b1;
        cyc();
        ticks_to_fault(100, n);
        check(n == 4, "R4", n, 4);

        // R6: chosen input keeps it alive, both edge directions
        cur_req = "R6";
        restart_off();
        cfg_clr_mode = 2'b01; cfg_gpi_sel = 2'd2; cfg_po_sel = 3'd5; cfg_enable = 1'b1;
        cyc();
        any_fault = 0;
        for (int r = 0; r < 10; r++) begin
            ticks(3);
            if (wd_fault === 1'b1) any_fault = 1;
            gpi[2] = ~gpi[2]; cyc();
        end
        check(any_fault == 0, "R6", int'(any_fault), 0);

        // R8: unselected input bit and unused output ignored
        cur_req = "R8";
        gpi[1] = ~gpi[1]; po[5] = ~po[5]; cyc();
        ticks_to_fault(100, n);
        check(n == 4, "R8", n, 4);

        // R7: chosen output keeps it alive, input ignored
        cur_req = "R7";
        cfg_clr_mode = 2'b10;
        po[5] = ~po[5]; cyc();
        any_fault = 0;
        for (int r = 0; r < 10; r++) begin
            ticks(3);
            if (wd_fault === 1'b1) any_fault = 1;
            po[5] = ~po[5]; cyc();
        end
        check(any_fault == 0, "R7", int'(any_fault), 0);
        ticks(3);
        gpi[2] = ~gpi[2]; cyc();
        ticks_to_fault(100, n);
        check(n == 1, "R7", n, 1);

        // R8: both sources, either restarts
        cur_req = "R8";
        cfg_clr_mode = 2'b11;
        gpi[2] = ~gpi[2]; cyc();
        any_fault = 0;
        for (int r = 0; r < 10; r++) begin
            ticks(3);
            if (wd_fault === 1'b1) any_fault = 1;
            if (r % 2 == 0) gpi[2] = ~gpi[2]; else po[5] = ~po[5];
            cyc();
        end
        check(any_fault == 0, "R8", int'(any_fault), 0);

        // R10: restart and tick in the same clock
        cur_req = "R10";
        cfg_clr_mode = 2'b01;
        ticks(3);
        tick = 1'b1; gpi[2] = ~gpi[2]; cyc(); tick = 1'b0;
        check(wd_fault === 1'b0, "R10", int'(wd_fault), 0);
        cyc();
        ticks_to_fault(100, n);
        check(n == 4, "R10", n, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule